// File: doc/BRIEF.md
# Peripheral Window Address Router

This block sits on the processor's bus path and picks a destination for each access. It holds a single configuration register. That register places a 64 KB window for the on-chip peripherals, switches the window on or off, and can hide the window from each of four address spaces. The four spaces are supervisor code, supervisor data, user code and user data. Each request brings a 32-bit address, a supervisor/user flag, a code/data flag, a hit flag from the on-chip memories and a hit flag from the chip-select comparators. The block answers, with no clock delay, by asserting exactly one of four selects: on-chip memory, internal peripheral, chip select, or external bus.

The configuration register has two write paths. A dedicated control path can load it at any time, and it is the only way to set it up before it is valid. Once the register is valid, a supervisor access at window offset 0x000 reads or writes it through the ordinary bus port. A user access to that offset is refused, and the refusal is flagged on an error output.

Top module: `mod_window_router`

## Requirements
- R1: After reset the valid flag (register bit 0) is 0. While it stays 0, no request asserts `selPeriph`.
- R2: When `reqValid` is 1, exactly one of `selMem`, `selPeriph`, `selChip`, `selExt` is 1. When `reqValid` is 0, all four are 0.
- R3: A valid request with `memHit` set asserts `selMem`, whatever the address, space or `csHit` value.
- R4: Without `memHit`, a request whose address bits 31:16 equal register bits 31:16 asserts `selPeriph` when the valid flag is 1 and its space is not masked. This holds even if `csHit` is set. Addresses just outside the 64 KB range do not match.
- R5: Mask bits are register bit 4 (supervisor code), bit 3 (supervisor data), bit 2 (user code) and bit 1 (user data). A masked access inside the window does not go to the peripheral. It asserts `selChip` if `csHit` is set, otherwise `selExt`.
- R6: A request with neither `memHit` nor a window match asserts `selChip` when `csHit` is 1, otherwise `selExt`.
- R7: A pulse on `ctlWrEn` loads `ctlWrData` into the register on that clock edge, whether or not the register is valid. Register bits 15:5 always read as 0.
- R8: A supervisor request routed to the peripheral at window offset 0x000 reads or writes the register. A read drives the register on `regRdData` with `regRdValid` high in the same cycle. A write stores `reqWdata` with bits 15:5 forced to 0. Other offsets, and masked accesses, give no register access.
- R9: A user request routed to the peripheral at offset 0x000 raises `accessErr` and leaves the register unchanged, whether it is a read or a write. A user read also gives no `regRdValid`.
- R10: A register write takes effect at the clock edge that ends the write cycle. Decoding in the write cycle itself still uses the old value.
- R11: If `ctlWrEn` and a supervisor bus write to the register fall in the same cycle, the control path value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A bus request is present this cycle |
| reqAddr | input | 32 | Request address |
| reqSuper | input | 1 | 1 = supervisor, 0 = user |
| reqCode | input | 1 | 1 = code fetch, 0 = data |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 32 | Write data for a register write through the bus |
| memHit | input | 1 | On-chip SRAM/ROM/cache claims the address |
| csHit | input | 1 | A chip-select comparator claims the address |
| ctlWrEn | input | 1 | Dedicated control-path write strobe |
| ctlWrData | input | 32 | Dedicated control-path write data |
| selMem | output | 1 | Serve from on-chip memory |
| selPeriph | output | 1 | Run an internal peripheral cycle |
| selChip | output | 1 | Run a chip-select cycle |
| selExt | output | 1 | Run a plain external bus cycle |
| regRdData | output | 32 | Register read data, zero when no read |
| regRdValid | output | 1 | `regRdData` carries a register read |
| accessErr | output | 1 | User access to the register refused |

## Verification
The bench builds the block with its default parameters: a 32-bit address and 16 window bits, which gives a 64 KB window with the base in bits 31:16. These values bring into reach the window edges one word below and one page above the base. They also expose the full four-bit mask field and the reserved bits 15:5 that must read back as zero. The table sweeps every mask bit against each space and mixes in memory and chip-select hits. Directed cases then cover the old-value decode during a write, refused user accesses and the collision between the two write paths.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  // Destination chosen for one bus request, highest priority first.
  typedef enum logic [1:0] {
    TGT_MEM    = 2'd0,
    TGT_PERIPH = 2'd1,
    TGT_CHIP   = 2'd2,
    TGT_EXT    = 2'd3
  } target_e;

  localparam int NUM_TGT = 4;

  // Datapath -> control: what the current address looks like.
  typedef struct packed {
    logic winHit;      // inside an enabled window
    logic spaceMasked; // the request's space is hidden
    logic offsetZero;  // offset selects the configuration register
  } matchInfo_t;

  // Control -> datapath: register strobes.
  typedef struct packed {
    logic ctlLoad;  // load from the dedicated control path
    logic busLoad;  // load from the bus write data
    logic rdEn;     // drive register on the read port
  } regStrobe_t;

endpackage

// File: rtl/mwr_datapath.sv
module mwr_datapath
  import mwr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 16,
  parameter int REG_OFS  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSuper,
  input  logic              reqCode,
  input  logic [ADDR_W-1:0] reqWdata,
  input  logic [ADDR_W-1:0] ctlWrData,
  input  regStrobe_t        stb,
  output matchInfo_t        info,
  output logic [ADDR_W-1:0] regValue,
  output logic [ADDR_W-1:0] rdData
);

  localparam int BASE_W = ADDR_W - WIN_BITS;
  localparam int RSV_W  = WIN_BITS - 5;

  logic [BASE_W-1:0] baseQ;
  logic [3:0]        maskQ;
  logic              validQ;

  logic [ADDR_W-1:0] loadWord;
  logic              loadEn;
  logic              unusedRsvd;

  // Control path wins over the bus when both fire in one cycle.
  assign loadWord = stb.ctlLoad ? ctlWrData : reqWdata;
  assign loadEn   = stb.ctlLoad | stb.busLoad;

  // Base field carries no reset value.
  always_ff @(posedge clk) begin
    if (loadEn) baseQ <= loadWord[ADDR_W-1:WIN_BITS];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      validQ <= 1'b0;
    end else if (loadEn) begin
      maskQ  <= loadWord[4:1];
      validQ <= loadWord[0];
    end
  end

  assign unusedRsvd = ^{ctlWrData[WIN_BITS-1:5], reqWdata[WIN_BITS-1:5]};

  assign regValue = {baseQ, {RSV_W{1'b0}}, maskQ, validQ};

  always_comb begin
    info.winHit      = validQ && (reqAddr[ADDR_W-1:WIN_BITS] == baseQ);
    // maskQ[3]=sup code, [2]=sup data, [1]=user code, [0]=user data
    info.spaceMasked = maskQ[{reqSuper, reqCode}];
    info.offsetZero  = (reqAddr[WIN_BITS-1:0] == WIN_BITS'(REG_OFS));
  end

  assign rdData = stb.rdEn ? regValue : '0;

endmodule

// File: rtl/mwr_ctrl.sv
module mwr_ctrl
  import mwr_pkg::*;
(
  input  logic               reqValid,
  input  logic               reqSuper,
  input  logic               reqWrite,
  input  logic               memHit,
  input  logic               csHit,
  input  logic               ctlWrEn,
  input  matchInfo_t         info,
  output logic [NUM_TGT-1:0] selVec,
  output regStrobe_t         stb,
  output logic               accessErr,
  output logic               rdValid
);

  target_e tgt;
  logic    periphOk;
  logic    regAccess;

  assign periphOk = info.winHit && !info.spaceMasked;

  // Fixed priority: on-chip memory, window, chip select, external.
  always_comb begin
    if (memHit)        tgt = TGT_MEM;
    else if (periphOk) tgt = TGT_PERIPH;
    else if (csHit)    tgt = TGT_CHIP;
    else               tgt = TGT_EXT;
  end

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_sel
    assign selVec[i] = reqValid && (tgt == target_e'(i));
  end

  assign regAccess = reqValid && (tgt == TGT_PERIPH) && info.offsetZero;

  always_comb begin
    stb.ctlLoad = ctlWrEn;
    stb.busLoad = regAccess && reqSuper && reqWrite && !ctlWrEn;
    stb.rdEn    = regAccess && reqSuper && !reqWrite;
  end

  assign accessErr = regAccess && !reqSuper;
  assign rdValid   = stb.rdEn;

endmodule

// File: rtl/mod_window_router.sv
module mod_window_router
  import mwr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 16,
  parameter int REG_OFS  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSuper,
  input  logic              reqCode,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqWdata,
  input  logic              memHit,
  input  logic              csHit,
  input  logic              ctlWrEn,
  input  logic [ADDR_W-1:0] ctlWrData,
  output logic              selMem,
  output logic              selPeriph,
  output logic              selChip,
  output logic              selExt,
  output logic [ADDR_W-1:0] regRdData,
  output logic              regRdValid,
  output logic              accessErr
);

  matchInfo_t         info;
  regStrobe_t         stb;
  logic [NUM_TGT-1:0] selVec;
  logic [ADDR_W-1:0]  regValue;

  mwr_datapath #(
    .ADDR_W  (ADDR_W),
    .WIN_BITS(WIN_BITS),
    .REG_OFS (REG_OFS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqAddr  (reqAddr),
    .reqSuper (reqSuper),
    .reqCode  (reqCode),
    .reqWdata (reqWdata),
    .ctlWrData(ctlWrData),
    .stb      (stb),
    .info     (info),
    .regValue (regValue),
    .rdData   (regRdData)
  );

  mwr_ctrl ctrl_i (
    .reqValid (reqValid),
    .reqSuper (reqSuper),
    .reqWrite (reqWrite),
    .memHit   (memHit),
    .csHit    (csHit),
    .ctlWrEn  (ctlWrEn),
    .info     (info),
    .selVec   (selVec),
    .stb      (stb),
    .accessErr(accessErr),
    .rdValid  (regRdValid)
  );

  assign selMem    = selVec[TGT_MEM];
  assign selPeriph = selVec[TGT_PERIPH];
  assign selChip   = selVec[TGT_CHIP];
  assign selExt    = selVec[TGT_EXT];

endmodule

// File: rtl/mod_window_router_chk.sv
module mod_window_router_chk #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqSuper,
  input logic              reqCode,
  input logic              memHit,
  input logic              ctlWrEn,
  input logic [ADDR_W-1:0] ctlWrData,
  input logic              selMem,
  input logic              selPeriph,
  input logic              selChip,
  input logic              selExt,
  input logic [ADDR_W-1:0] regRdData,
  input logic              regRdValid,
  input logic              accessErr,
  input logic [ADDR_W-1:0] regValue
);

  logic [3:0] maskNow;
  logic       inWin;
  logic       unusedChk;

  assign maskNow   = regValue[4:1];
  assign inWin     = reqAddr[ADDR_W-1:WIN_BITS] == regValue[ADDR_W-1:WIN_BITS];
  assign unusedChk = ^ctlWrData[WIN_BITS-1:5];

  p_invalid_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !regValue[0] |-> !selPeriph);

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $countones({selMem, selPeriph, selChip, selExt}) == 1);

  p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> {selMem, selPeriph, selChip, selExt} == 4'b0000);

  p_mem_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && memHit |-> selMem);

  p_masked_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && inWin && maskNow[{reqSuper, reqCode}] |-> !selPeriph);

  p_ctl_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn |=> (regValue[ADDR_W-1:WIN_BITS] == $past(ctlWrData[ADDR_W-1:WIN_BITS]))
             && (regValue[4:0] == $past(ctlWrData[4:0])));

  p_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    regRdValid |-> reqSuper && selPeriph && (regRdData == regValue));

  p_err_user_r9: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> !reqSuper && selPeriph && !regRdValid);

  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    accessErr && !ctlWrEn |=> $stable(regValue));

endmodule

bind mod_window_router mod_window_router_chk #(
  .ADDR_W  (ADDR_W),
  .WIN_BITS(WIN_BITS)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqAddr   (reqAddr),
  .reqSuper  (reqSuper),
  .reqCode   (reqCode),
  .memHit    (memHit),
  .ctlWrEn   (ctlWrEn),
  .ctlWrData (ctlWrData),
  .selMem    (selMem),
  .selPeriph (selPeriph),
  .selChip   (selChip),
  .selExt    (selExt),
  .regRdData (regRdData),
  .regRdValid(regRdValid),
  .accessErr (accessErr),
  .regValue  (regValue)
);

// File: tb/mod_window_router_tb_top.sv
module mod_window_router_tb_top;

  localparam logic [3:0] MEM = 4'b1000;
  localparam logic [3:0] PER = 4'b0100;
  localparam logic [3:0] CHP = 4'b0010;
  localparam logic [3:0] EXT = 4'b0001;

  typedef struct packed {
    logic [31:0] cfg;
    logic [31:0] addr;
    logic        sup;
    logic        code;
    logic        mem;
    logic        cs;
    logic [3:0]  exp;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{32'h1000_0001, 32'h1000_0040, 1'b1, 1'b0, 1'b0, 1'b0, PER},
    '{32'h1000_0001, 32'h1000_0040, 1'b1, 1'b0, 1'b1, 1'b0, MEM},
    '{32'h1000_0001, 32'h1000_0040, 1'b1, 1'b0, 1'b0, 1'b1, PER},
    '{32'h1000_0001, 32'h2000_0000, 1'b1, 1'b0, 1'b0, 1'b1, CHP},
    '{32'h1000_0001, 32'h2000_0000, 1'b0, 1'b1, 1'b0, 1'b0, EXT},
    '{32'h1000_0001, 32'h1001_0000, 1'b1, 1'b0, 1'b0, 1'b0, EXT},
    '{32'h1000_0001, 32'h0FFF_FFFC, 1'b1, 1'b0, 1'b0, 1'b0, EXT},
    '{32'h1000_0001, 32'h1000_FFFC, 1'b0, 1'b1, 1'b0, 1'b0, PER},
    '{32'h1000_0001, 32'h2000_0000, 1'b0, 1'b0, 1'b1, 1'b1, MEM},
    '{32'h1000_0011, 32'h1000_0040, 1'b1, 1'b1, 1'b0, 1'b0, EXT},
    '{32'h1000_0011, 32'h1000_0040, 1'b1, 1'b0, 1'b0, 1'b0, PER},
    '{32'h1000_0011, 32'h1000_0040, 1'b0, 1'b1, 1'b0, 1'b0, PER},
    '{32'h1000_0009, 32'h1000_0040, 1'b1, 1'b0, 1'b0, 1'b1, CHP},
    '{32'h1000_0009, 32'h1000_0040, 1'b1, 1'b0, 1'b0, 1'b0, EXT},
    '{32'h1000_0009, 32'h1000_0040, 1'b1, 1'b1, 1'b0, 1'b0, PER},
    '{32'h1000_0005, 32'h1000_0040, 1'b0, 1'b1, 1'b0, 1'b0, EXT},
    '{32'h1000_0005, 32'h1000_0040, 1'b0, 1'b0, 1'b0, 1'b0, PER},
    '{32'h1000_0003, 32'h1000_0040, 1'b0, 1'b0, 1'b0, 1'b0, EXT},
    '{32'h1000_0003, 32'h1000_0040, 1'b0, 1'b1, 1'b0, 1'b0, PER},
    '{32'h1000_0003, 32'h1000_0040, 1'b0, 1'b0, 1'b1, 1'b0, MEM},
    '{32'h1000_0000, 32'h1000_0040, 1'b1, 1'b0, 1'b0, 1'b0, EXT},
    '{32'h1000_0000, 32'h1000_0040, 1'b1, 1'b0, 1'b0, 1'b1, CHP},
    '{32'h1000_001F, 32'h1000_0040, 1'b1, 1'b1, 1'b0, 1'b1, CHP}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqSuper = 1'b0;
  logic        reqCode = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        memHit = 1'b0;
  logic        csHit = 1'b0;
  logic        ctlWrEn = 1'b0;
  logic [31:0] ctlWrData = '0;
  logic        selMem, selPeriph, selChip, selExt;
  logic [31:0] regRdData;
  logic        regRdValid, accessErr;

  int checks = 0;
  int errors = 0;
  logic [31:0] curCfg = 32'hFFFF_FFFF;

  always #10 clk = ~clk;

  mod_window_router dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSuper(reqSuper), .reqCode(reqCode), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .memHit(memHit), .csHit(csHit),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .selMem(selMem),
    .selPeriph(selPeriph), .selChip(selChip), .selExt(selExt),
    .regRdData(regRdData), .regRdValid(regRdValid), .accessErr(accessErr)
  );

  function automatic logic [3:0] selNow();
    return {selMem, selPeriph, selChip, selExt};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ctlWrite(input logic [31:0] v);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    ctlWrEn = 1'b1; ctlWrData = v;
    @(negedge clk);
    ctlWrEn = 1'b0;
    curCfg = v;
  endtask

  task automatic setReq(input logic [31:0] a, input logic s, input logic c,
                        input logic w, input logic [31:0] wd,
                        input logic m, input logic cs);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqSuper = s; reqCode = c;
    reqWrite = w; reqWdata = wd; memHit = m; csHit = cs;
    #2;
  endtask

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: valid flag clear after reset, window never matches
    setReq(32'h1000_0040, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    check("R1 reset route", {28'b0, selNow()}, {28'b0, EXT});
    check("R1 reset no error", {31'b0, accessErr | regRdValid}, 32'd0);

    // R2: no request, no select
    @(negedge clk); reqValid = 1'b0; #2;
    check("R2 idle selects", {28'b0, selNow()}, 32'd0);

    // R7/R8: control load, reserved bits dropped, supervisor readback
    ctlWrite(32'h1000_FFE1);
    setReq(32'h1000_0000, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    check("R7 readback data", regRdData, 32'h1000_0001);
    check("R8 read valid", {31'b0, regRdValid}, 32'd1);

    // R2/R3/R4/R5/R6: routing table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].cfg != curCfg) ctlWrite(VECS[i].cfg);
      setReq(VECS[i].addr, VECS[i].sup, VECS[i].code, 1'b0, '0,
             VECS[i].mem, VECS[i].cs);
      check($sformatf("R2/R3/R4/R5/R6 vector %0d", i),
            {28'b0, selNow()}, {28'b0, VECS[i].exp});
    end

    // R9: user write refused, register kept
    ctlWrite(32'h1000_0001);
    setReq(32'h1000_0000, 1'b0, 1'b0, 1'b1, 32'h2000_0001, 1'b0, 1'b0);
    check("R9 user write error", {31'b0, accessErr}, 32'd1);
    setReq(32'h1000_0000, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    check("R9 register kept", regRdData, 32'h1000_0001);
    setReq(32'h1000_0000, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0);
    check("R9 user read error", {31'b0, accessErr}, 32'd1);
    check("R9 user read no data", {31'b0, regRdValid}, 32'd0);

    // R10/R8: bus write, old decode in write cycle, new after edge
    setReq(32'h1000_0000, 1'b1, 1'b0, 1'b1, 32'h3000_FFE1, 1'b0, 1'b0);
    check("R10 old value in write cycle", {31'b0, selPeriph}, 32'd1);
    setReq(32'h1000_0000, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    check("R10 old base gone", {28'b0, selNow()}, {28'b0, EXT});
    setReq(32'h3000_0000, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    check("R8 bus write readback", regRdData, 32'h3000_0001);
    setReq(32'h3000_0004, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    check("R8 nonzero offset no read", {31'b0, regRdValid}, 32'd0);

    // R11: control path beats bus write in the same cycle
    @(negedge clk);
    ctlWrEn = 1'b1; ctlWrData = 32'h4000_0001;
    reqValid = 1'b1; reqAddr = 32'h3000_0000; reqSuper = 1'b1; reqCode = 1'b0;
    reqWrite = 1'b1; reqWdata = 32'h5000_0001; memHit = 1'b0; csHit = 1'b0;
    @(negedge clk); ctlWrEn = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    setReq(32'h4000_0000, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    check("R11 control path wins", regRdData, 32'h4000_0001);

    // R8: masked supervisor data access reaches no register
    ctlWrite(32'h4000_0009);
    setReq(32'h4000_0000, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    check("R8 masked no read", {31'b0, regRdValid}, 32'd0);
    check("R5 masked goes external", {28'b0, selNow()}, {28'b0, EXT});

    @(negedge clk); reqValid = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule